// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits on the path between a processor core and memory and decides, for every access, whether the access may go ahead. Software programs up to eight protection regions through a register-write port. Each region has a base address, a power-of-two size, an enable bit, a separate permission setting for privileged and user mode, and cacheable and bufferable attribute bits. The core presents each access as an address, a read/write direction, an instruction-fetch flag and the current mode.

One cycle after a request the block answers with either a grant, carrying the winning region's number and its cacheable and bufferable bits, or an abort. An abort is marked as a prefetch abort when the faulting access was an instruction fetch and as a data abort otherwise. The response stays on the outputs until the next request arrives. A global enable input turns checking off. While it is off, every access is granted with both attributes clear.

Top module: `region_guard`

## Requirements
- R1: Eight regions, indexed 0 to 7 by `cfg_idx`, are written by a one-cycle `cfg_we` pulse, and each of them can win a match. After reset every region is disabled, so with checking on every request aborts.
- R2: `cfg_size` is a code N that gives a region of 2^(N+1) bytes. Only N from 11 (4 KB) to 31 (4 GB) is valid. A region with any other code never matches, even when its enable bit is set.
- R3: An address falls in a region when it equals the base with the low N+1 bits of both cleared. Low base bits written below the region's alignment are accepted and ignored.
- R4: The permission used is `cfg_perm_priv` when `req_priv`=1 and `cfg_perm_user` otherwise. The encodings are: 2'b00 no access, 2'b01 read-only, 2'b10 or 2'b11 read/write. A write needs read/write. A read needs read-only or read/write.
- R5: An instruction fetch (`req_fetch`=1) is checked as a read. The abort type is `rsp_abort_fetch`=1 for a fetch (prefetch abort) and 0 for a data access (data abort).
- R6: When regions overlap, the matching enabled region with the highest index alone decides the outcome, even if a lower-indexed region would allow the access. An address matched by no enabled region aborts.
- R7: A grant drives `rsp_region` with the winning index and copies that region's cacheable and bufferable bits to `rsp_cache` and `rsp_buf`. An abort drives `rsp_region`, `rsp_cache` and `rsp_buf` to 0. `rsp_grant` and `rsp_abort` are never both 1.
- R8: `rsp_valid` is 1 for exactly the cycle after a `req_valid` cycle. All other response outputs take their new values in that same cycle and hold them until the next request.
- R9: While `guard_on`=0, every request is granted with `rsp_region`=0, `rsp_cache`=0 and `rsp_buf`=0, whatever the regions hold.
- R10: Synchronous active-high reset clears `rsp_valid`, `rsp_grant`, `rsp_abort`, `rsp_abort_fetch`, `rsp_region`, `rsp_cache` and `rsp_buf`.
- R11: A region whose enable bit is 0 never matches, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| guard_on | input | 1 | Global checking enable |
| cfg_we | input | 1 | Region register write strobe |
| cfg_idx | input | 3 | Region index to write |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Size code N (2^(N+1) bytes) |
| cfg_en | input | 1 | Region enable |
| cfg_perm_priv | input | 2 | Privileged-mode permission |
| cfg_perm_user | input | 2 | User-mode permission |
| cfg_cache | input | 1 | Region cacheable attribute |
| cfg_buf | input | 1 | Region bufferable attribute |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_fetch | input | 1 | Instruction fetch flag |
| req_priv | input | 1 | 1 for privileged mode, 0 for user mode |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_grant | output | 1 | Access granted |
| rsp_abort | output | 1 | Access aborted |
| rsp_abort_fetch | output | 1 | Abort type: 1 prefetch, 0 data |
| rsp_region | output | 3 | Winning region index on a grant |
| rsp_cache | output | 1 | Cacheable attribute of the grant |
| rsp_buf | output | 1 | Bufferable attribute of the grant |

## Verification
The hardest cases to reach from the ports are nested regions, where the higher-indexed region refuses an access that a lower-indexed region would allow, and a region whose base was written with bits below its alignment. The bench programs a 4 GB background region, a 64 KB region with an 8 KB region nested inside it, a 4 KB region with a misaligned base, and regions that are disabled or have an invalid size code. It then probes addresses just inside and just outside each boundary, in both modes and for every access kind. Later directed steps disable the background region, so that unmatched addresses and a match in region 7 can also be observed.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

    localparam int unsigned ADDR_W        = 32;
    localparam int unsigned SIZE_W        = 5;
    localparam int unsigned MIN_SIZE_CODE = 11;
    localparam int unsigned MAX_SIZE_CODE = ADDR_W - 1;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b10,
        PERM_RW2  = 2'b11
    } perm_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size_code;
        logic              enable;
        perm_e             perm_priv;
        perm_e             perm_user;
        logic              cacheable;
        logic              bufferable;
    } region_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              fetch;
        logic              priv;
    } access_t;

    // A size code outside the legal span turns the region off.
    function automatic logic size_code_ok(input logic [SIZE_W-1:0] code);
        return (32'(code) >= MIN_SIZE_CODE) && (32'(code) <= MAX_SIZE_CODE);
    endfunction

    // Ones above the region's span and zeros inside it.
    function automatic logic [ADDR_W-1:0] span_mask(input logic [SIZE_W-1:0] code);
        return {ADDR_W{1'b1}} << (32'(code) + 32'd1);
    endfunction

    // Reads need any access, writes need the read/write setting.
    function automatic logic perm_allows(input perm_e p, input logic is_write);
        return is_write ? p[1] : (p != PERM_NONE);
    endfunction

endpackage

// File: rtl/rgn_regfile.sv
module rgn_regfile
    import rgn_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 8,
    localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  region_t          wr_data,
    output region_t          regions [NUM_REGIONS]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                regions[i] <= '0;
            end
        end else if (wr_en) begin
            regions[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/rgn_match.sv
module rgn_match
    import rgn_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 8
) (
    input  region_t                regions [NUM_REGIONS],
    input  logic [ADDR_W-1:0]      addr,
    output logic [NUM_REGIONS-1:0] hit
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        logic              live;
        logic [ADDR_W-1:0] mask;

        assign live   = regions[g].enable && size_code_ok(regions[g].size_code);
        assign mask   = span_mask(regions[g].size_code);
        // Low base bits under the alignment drop out through the mask.
        assign hit[g] = live && (((addr ^ regions[g].base) & mask) == '0);
    end

endmodule

// File: rtl/rgn_select.sv
module rgn_select #(
    parameter int unsigned NUM_REGIONS = 8,
    localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] hit,
    output logic                   found,
    output logic [IDX_W-1:0]       sel
);

    // Ascending scan: the last hit seen, the highest index, wins.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit[i]) begin
                found = 1'b1;
                sel   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import rgn_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 8,
    localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              guard_on,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_perm_priv,
    input  logic [1:0]        cfg_perm_user,
    input  logic              cfg_cache,
    input  logic              cfg_buf,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic              req_priv,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_abort,
    output logic              rsp_abort_fetch,
    output logic [IDX_W-1:0]  rsp_region,
    output logic              rsp_cache,
    output logic              rsp_buf
);

    region_t                regions [NUM_REGIONS];
    region_t                wr_data;
    access_t                acc;
    logic [NUM_REGIONS-1:0] hit;
    logic                   found;
    logic [IDX_W-1:0]       win_idx;
    perm_e                  perm;
    logic                   allowed;

    assign wr_data = '{
        base:       cfg_base,
        size_code:  cfg_size,
        enable:     cfg_en,
        perm_priv:  perm_e'(cfg_perm_priv),
        perm_user:  perm_e'(cfg_perm_user),
        cacheable:  cfg_cache,
        bufferable: cfg_buf
    };

    assign acc = '{addr: req_addr, write: req_write, fetch: req_fetch, priv: req_priv};

    rgn_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regfile (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (wr_data),
        .regions (regions)
    );

    rgn_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
        .regions (regions),
        .addr    (acc.addr),
        .hit     (hit)
    );

    rgn_select #(.NUM_REGIONS(NUM_REGIONS)) u_select (
        .hit   (hit),
        .found (found),
        .sel   (win_idx)
    );

    // A fetch is checked as a read.
    always_comb begin
        perm    = acc.priv ? regions[win_idx].perm_priv : regions[win_idx].perm_user;
        allowed = found && perm_allows(perm, acc.write && !acc.fetch);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid       <= 1'b0;
            rsp_grant       <= 1'b0;
            rsp_abort       <= 1'b0;
            rsp_abort_fetch <= 1'b0;
            rsp_region      <= '0;
            rsp_cache       <= 1'b0;
            rsp_buf         <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                if (!guard_on) begin
                    rsp_grant       <= 1'b1;
                    rsp_abort       <= 1'b0;
                    rsp_abort_fetch <= 1'b0;
                    rsp_region      <= '0;
                    rsp_cache       <= 1'b0;
                    rsp_buf         <= 1'b0;
                end else if (allowed) begin
                    rsp_grant       <= 1'b1;
                    rsp_abort       <= 1'b0;
                    rsp_abort_fetch <= 1'b0;
                    rsp_region      <= win_idx;
                    rsp_cache       <= regions[win_idx].cacheable;
                    rsp_buf         <= regions[win_idx].bufferable;
                end else begin
                    rsp_grant       <= 1'b0;
                    rsp_abort       <= 1'b1;
                    rsp_abort_fetch <= acc.fetch;
                    rsp_region      <= '0;
                    rsp_cache       <= 1'b0;
                    rsp_buf         <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
    parameter int unsigned IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             guard_on,
    input logic             req_valid,
    input logic             req_fetch,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic             rsp_abort,
    input logic             rsp_abort_fetch,
    input logic [IDX_W-1:0] rsp_region,
    input logic             rsp_cache,
    input logic             rsp_buf
);

    assert_resp_follows_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_resp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable({rsp_grant, rsp_abort, rsp_abort_fetch, rsp_region, rsp_cache, rsp_buf}));

    assert_grant_abort_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(rsp_grant && rsp_abort));

    assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_abort |-> (rsp_region == '0) && !rsp_cache && !rsp_buf);

    assert_abort_kind_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_abort || (rsp_abort_fetch == $past(req_fetch))));

    assert_bypass_grant_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !guard_on) |=> rsp_grant && !rsp_cache && !rsp_buf && (rsp_region == '0));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> !rsp_valid && !rsp_grant && !rsp_abort && !rsp_abort_fetch);

endmodule

bind region_guard region_guard_chk #(.IDX_W(IDX_W)) u_region_guard_chk (
    .clk             (clk),
    .rst             (rst),
    .guard_on        (guard_on),
    .req_valid       (req_valid),
    .req_fetch       (req_fetch),
    .rsp_valid       (rsp_valid),
    .rsp_grant       (rsp_grant),
    .rsp_abort       (rsp_abort),
    .rsp_abort_fetch (rsp_abort_fetch),
    .rsp_region      (rsp_region),
    .rsp_cache       (rsp_cache),
    .rsp_buf         (rsp_buf)
);

// File: tb/region_guard_bench.sv
`timescale 1ns/1ps
module region_guard_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        guard_on = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [4:0]  cfg_size = '0;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_perm_priv = '0;
    logic [1:0]  cfg_perm_user = '0;
    logic        cfg_cache = 1'b0;
    logic        cfg_buf = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic        req_priv = 1'b0;
    logic        rsp_valid, rsp_grant, rsp_abort, rsp_abort_fetch, rsp_cache, rsp_buf;
    logic [2:0]  rsp_region;
    logic [7:0]  got;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    region_guard u_region_guard (
        .clk(clk), .rst(rst), .guard_on(guard_on),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_en(cfg_en), .cfg_perm_priv(cfg_perm_priv), .cfg_perm_user(cfg_perm_user),
        .cfg_cache(cfg_cache), .cfg_buf(cfg_buf),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_fetch(req_fetch), .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_abort(rsp_abort),
        .rsp_abort_fetch(rsp_abort_fetch), .rsp_region(rsp_region),
        .rsp_cache(rsp_cache), .rsp_buf(rsp_buf)
    );

    // Packed response: grant, abort, abort_fetch, region[2:0], cache, buf.
    assign got = {rsp_grant, rsp_abort, rsp_abort_fetch, rsp_region, rsp_cache, rsp_buf};

    localparam logic [7:0] G_R0   = 8'b100_000_00;
    localparam logic [7:0] AB_DAT = 8'b010_000_00;
    localparam logic [7:0] AB_PF  = 8'b011_000_00;

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic        fe;
        logic        pv;
        logic [7:0]  exp;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 1'b0, 1'b0, 1'b0, G_R0},
        '{32'h0000_1000, 1'b1, 1'b0, 1'b0, AB_DAT},
        '{32'h0000_1000, 1'b1, 1'b0, 1'b1, G_R0},
        '{32'h0001_0004, 1'b0, 1'b0, 1'b1, 8'b100_001_11},
        '{32'h0001_0004, 1'b0, 1'b0, 1'b0, AB_DAT},
        '{32'h0001_0004, 1'b0, 1'b1, 1'b0, AB_PF},
        '{32'h0001_2FFC, 1'b1, 1'b0, 1'b1, AB_DAT},
        '{32'h0001_3FFC, 1'b1, 1'b0, 1'b0, 8'b100_010_10},
        '{32'h0001_4000, 1'b1, 1'b0, 1'b1, 8'b100_001_11},
        '{32'h8000_0000, 1'b1, 1'b0, 1'b0, 8'b100_101_01},
        '{32'h8000_1000, 1'b1, 1'b0, 1'b0, AB_DAT},
        '{32'h9000_0010, 1'b1, 1'b0, 1'b0, AB_DAT},
        '{32'hA000_0010, 1'b1, 1'b0, 1'b0, AB_DAT},
        '{32'hC000_3FFC, 1'b0, 1'b1, 1'b1, AB_PF},
        '{32'hC000_4000, 1'b0, 1'b1, 1'b1, G_R0},
        '{32'hFFFF_FFFC, 1'b0, 1'b1, 1'b0, G_R0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2:    return "R4";
            3, 7:       return "R7";
            4, 6, 14:   return "R6";
            5, 13, 15:  return "R5";
            8, 9, 10:   return "R3";
            11:         return "R11";
            default:    return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic prog(input logic [2:0] idx, input logic [31:0] base, input logic [4:0] size,
                        input logic en, input logic [1:0] pp, input logic [1:0] pu,
                        input logic c, input logic b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_size = size; cfg_en = en;
        cfg_perm_priv = pp; cfg_perm_user = pu; cfg_cache = c; cfg_buf = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one request cycle; the response is sampled on the following negedge.
    task automatic access(input logic [31:0] a, input logic w, input logic f, input logic p);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_fetch = f; req_priv = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        check("R10", "reset outputs", {24'd0, rsp_valid, got[7:1]}, 32'd0);
        check("R10", "reset low bits", {31'd0, got[0]}, 32'd0);
        rst = 1'b0;
        guard_on = 1'b1;

        // R1: no region programmed yet, so every request aborts
        access(32'h0000_1000, 1'b0, 1'b0, 1'b1);
        check("R1", "empty table abort", {24'd0, got}, {24'd0, AB_DAT});

        // Region map: perm 0 none, 1 read-only, 2 read/write
        prog(3'd0, 32'h0000_0000, 5'd31, 1'b1, 2'd2, 2'd1, 1'b0, 1'b0);
        prog(3'd1, 32'h0001_0000, 5'd15, 1'b1, 2'd2, 2'd0, 1'b1, 1'b1);
        prog(3'd2, 32'h0001_2000, 5'd12, 1'b1, 2'd1, 2'd3, 1'b1, 1'b0);
        prog(3'd3, 32'hC000_0000, 5'd13, 1'b1, 2'd0, 2'd0, 1'b1, 1'b1);
        prog(3'd5, 32'h8000_0123, 5'd11, 1'b1, 2'd2, 2'd2, 1'b0, 1'b1);
        prog(3'd6, 32'hA000_0000, 5'd5,  1'b1, 2'd2, 2'd2, 1'b1, 1'b1);
        prog(3'd7, 32'h9000_0000, 5'd20, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i].addr, VECS[i].wr, VECS[i].fe, VECS[i].pv);
            check("R8", $sformatf("vector %0d valid", i), {31'd0, rsp_valid}, 32'd1);
            check(vec_tag(i), $sformatf("vector %0d response", i), {24'd0, got}, {24'd0, VECS[i].exp});
        end

        // R8: response held through idle cycles after a prefetch abort
        access(32'hC000_0010, 1'b0, 1'b1, 1'b0);
        held = got;
        repeat (3) @(negedge clk);
        check("R8", "valid drops when idle", {31'd0, rsp_valid}, 32'd0);
        check("R8", "response held", {24'd0, got}, {24'd0, AB_PF});
        check("R8", "held equals first", {24'd0, got}, {24'd0, held});

        // R9: checking off grants even a no-access region
        guard_on = 1'b0;
        access(32'hC000_0000, 1'b1, 1'b0, 1'b0);
        check("R9", "bypass grant", {24'd0, got}, {24'd0, G_R0});
        access(32'h0001_0000, 1'b0, 1'b0, 1'b1);
        check("R9", "bypass clears attributes", {24'd0, got}, {24'd0, G_R0});
        guard_on = 1'b1;

        // R6: background region removed, unmatched addresses abort
        prog(3'd0, 32'h0000_0000, 5'd31, 1'b0, 2'd2, 2'd2, 1'b0, 1'b0);
        access(32'h4000_0000, 1'b0, 1'b1, 1'b0);
        check("R6", "unmatched fetch", {24'd0, got}, {24'd0, AB_PF});
        access(32'h4000_0000, 1'b0, 1'b0, 1'b1);
        check("R6", "unmatched read", {24'd0, got}, {24'd0, AB_DAT});

        // R2: size code 10 is below the legal span
        prog(3'd0, 32'h0000_0000, 5'd10, 1'b1, 2'd2, 2'd2, 1'b0, 1'b0);
        access(32'h0000_0100, 1'b0, 1'b0, 1'b1);
        check("R2", "short size code ignored", {24'd0, got}, {24'd0, AB_DAT});

        // R1: region 7 enabled now, 2 MB span
        prog(3'd7, 32'h9000_0000, 5'd20, 1'b1, 2'd2, 2'd2, 1'b1, 1'b1);
        access(32'h901F_FFFC, 1'b1, 1'b0, 1'b0);
        check("R1", "region 7 grant", {24'd0, got}, {24'd0, 8'b100_111_11});
        access(32'h9020_0000, 1'b1, 1'b0, 1'b0);
        check("R3", "past region 7 end", {24'd0, got}, {24'd0, AB_DAT});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule